// File: doc/BRIEF.md
# Transmit Word Queue with Release Control

This block buffers outgoing 32-bit words between a host-side write port and a word serializer. A host interface pushes words with a one-cycle write strobe. The block holds them in a 32-entry first-in first-out store and decides when to offer them to the serializer. The serializer takes a word with a ready/valid handshake and reports the end of that word's transmission with a one-cycle done pulse. At most one word is outstanding at a time.

Release follows one of two policies, chosen by `auto_mode`:

- **Automatic release:** the burst starts when the host signals the end of the command that loaded the words (`load_end`).
- **Software release:** stored words stay held until an explicit start command (`start_cmd`). That start then drains the queue, including any words added while the burst runs.

A burst ends when the queue is empty and the last outstanding word has been reported done. After that, new words wait for the next trigger.

The block produces three status flags (empty, half-full, full) and one interrupt flag. The interrupt flag shows either the empty flag or the full flag, as selected by an input. A clear command empties the queue immediately. A master reset also drops the outstanding word, pulses a flush output towards the serializer, and forces all flags low for one cycle.

Top module: `txq_send_ctrl`

## Requirements
- R1: The queue holds 32 words and releases them in write order. A write accepted at 31 stored words sets `full_flag` to 1 at that clock edge. A write presented while 32 words are stored is dropped and is never offered to the serializer.
- R2: `half_flag` is 0 while 15 or fewer words are stored and 1 while 16 or more are stored. It changes at the clock edge that changes the stored count.
- R3: With `auto_mode`=1, stored words are not offered (`word_valid`=0) until a `load_end` pulse. From the cycle after that pulse, the oldest word is offered.
- R4: With `auto_mode`=0, a `start_cmd` pulse releases every stored word, including words written after the start but before the burst ends. With `auto_mode`=0 a `load_end` pulse has no effect, and with `auto_mode`=1 a `start_cmd` pulse has no effect.
- R5: With `auto_mode`=0, words written after a burst has ended (queue empty and last word done) stay held until the next `start_cmd`.
- R6: `empty_flag` is 0 while a taken word awaits its `word_done` pulse, even with no word stored. It becomes 1 at the clock edge that samples that `word_done` pulse.
- R7: `irq_flag` equals `empty_flag` when `flag_sel`=0 and `full_flag` when `flag_sel`=1. It is updated at each clock edge.
- R8: A `clear_cmd` pulse leaves zero words stored after the clock edge and a write in the same cycle is dropped. A word already taken by the serializer keeps `empty_flag` at 0 until its `word_done` pulse, and no further word is offered.
- R9: A `mreset` pulse drives `ser_flush`=1 in the same cycle. After the clock edge the queue is empty, the outstanding word is forgotten, and all of `empty_flag`, `half_flag`, `full_flag` and `irq_flag` are 0 for one cycle. After the next edge the flags reflect the empty queue.
- R10: A write accepted in the same cycle as a take leaves the stored count unchanged. Flags are computed from the count after both updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mreset | input | 1 | Master reset pulse: empties queue, drops outstanding word, zeroes flags |
| clear_cmd | input | 1 | Queue clear pulse |
| auto_mode | input | 1 | 1: release on `load_end`; 0: release on `start_cmd` |
| flag_sel | input | 1 | Interrupt source: 0 = empty flag, 1 = full flag |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 32 | Word to store |
| load_end | input | 1 | End of the host command that loaded words |
| start_cmd | input | 1 | Software start-of-burst pulse |
| word_valid | output | 1 | A word is offered to the serializer |
| word_data | output | 32 | Offered word |
| word_ready | input | 1 | Serializer takes the offered word |
| word_done | input | 1 | Serializer finished sending the taken word |
| ser_flush | output | 1 | Abort request to the serializer during master reset |
| empty_flag | output | 1 | Queue empty and no word outstanding |
| half_flag | output | 1 | 16 or more words stored |
| full_flag | output | 1 | 32 words stored |
| irq_flag | output | 1 | Selected interrupt flag |

## Verification
The hardest situation to create from the ports is a write landing in exactly the cycle a word is taken while the half-full boundary is being straddled. A miscounted simultaneous update shows only as a flag edge one word early or late. The bench fills the queue to exactly 16 words under software release, issues the start, and then raises `wr_en` and `word_ready` together in one cycle. It checks that `half_flag` stays 1, and then that a following take alone drops it to 0. A clear issued while a word is outstanding is reached the same way. The empty flag must stay low until the serializer's late done pulse, with no further word offered.

// File: rtl/txq_pkg.sv
package txq_pkg;

  localparam int unsigned TXQ_DEPTH = 32;
  localparam int unsigned TXQ_WIDTH = 32;

  // stored count after one cycle of push / pop / flush
  function automatic int unsigned txq_next_level(input int unsigned lvl,
                                                 input logic push,
                                                 input logic pop,
                                                 input logic flush);
    int unsigned n;
    if (flush) begin
      n = 0;
    end else begin
      n = lvl;
      if (push) n = n + 1;
      if (pop && n != 0) n = n - 1;
    end
    return n;
  endfunction

  function automatic logic txq_is_half(input int unsigned lvl, input int unsigned depth);
    return lvl >= (depth / 2);
  endfunction

  function automatic logic txq_is_full(input int unsigned lvl, input int unsigned depth);
    return lvl >= depth;
  endfunction

  function automatic logic txq_is_idle(input int unsigned lvl, input logic outstanding);
    return (lvl == 0) && !outstanding;
  endfunction

endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  assign rdata = mem[rd_ptr];

endmodule

// File: rtl/txq_level.sv
module txq_level
  import txq_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_req,
  input  logic             pop,
  output logic             push_ok,
  output logic [CNT_W-1:0] level_q,
  output logic [CNT_W-1:0] level_nxt
);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  // a write while full is dropped, a flush drops a same-cycle write
  assign push_ok   = wr_req && (level_q != FULL_LVL) && !flush;
  assign level_nxt = CNT_W'(txq_next_level(32'(level_q), push_ok, pop, flush));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_nxt;
  end

endmodule

// File: rtl/txq_release.sv
module txq_release #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mreset,
  input  logic             clear_cmd,
  input  logic             auto_mode,
  input  logic             load_end,
  input  logic             start_cmd,
  input  logic [CNT_W-1:0] level_q,
  input  logic [CNT_W-1:0] level_nxt,
  input  logic             word_ready,
  input  logic             word_done,
  output logic             word_valid,
  output logic             take,
  output logic             armed_q,
  output logic             infl_q,
  output logic             infl_nxt
);
  logic arm_set;
  logic burst_over;
  logic armed_nxt;

  // the trigger depends on the release policy; the other trigger is ignored
  assign arm_set    = auto_mode ? load_end : start_cmd;
  assign word_valid = armed_q && (level_q != '0) && !infl_q && !clear_cmd && !mreset;
  assign take       = word_valid && word_ready;

  always_comb begin
    if (mreset)         infl_nxt = 1'b0;
    else if (take)      infl_nxt = 1'b1;
    else if (word_done) infl_nxt = 1'b0;
    else                infl_nxt = infl_q;
  end

  assign burst_over = (level_nxt == '0) && !infl_nxt;

  always_comb begin
    if (mreset)          armed_nxt = 1'b0;
    else if (arm_set)    armed_nxt = 1'b1;
    else if (burst_over) armed_nxt = 1'b0;
    else                 armed_nxt = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      infl_q  <= 1'b0;
    end else begin
      armed_q <= armed_nxt;
      infl_q  <= infl_nxt;
    end
  end

endmodule

// File: rtl/txq_flags.sv
module txq_flags
  import txq_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mreset,
  input  logic             flag_sel,
  input  logic [CNT_W-1:0] level_nxt,
  input  logic             infl_nxt,
  output logic             empty_flag,
  output logic             half_flag,
  output logic             full_flag,
  output logic             irq_flag
);
  logic empty_c, half_c, full_c;

  assign empty_c = txq_is_idle(32'(level_nxt), infl_nxt);
  assign half_c  = txq_is_half(32'(level_nxt), DEPTH);
  assign full_c  = txq_is_full(32'(level_nxt), DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_flag <= 1'b0;
      half_flag  <= 1'b0;
      full_flag  <= 1'b0;
      irq_flag   <= 1'b0;
    end else if (mreset) begin
      empty_flag <= 1'b0;
      half_flag  <= 1'b0;
      full_flag  <= 1'b0;
      irq_flag   <= 1'b0;
    end else begin
      empty_flag <= empty_c;
      half_flag  <= half_c;
      full_flag  <= full_c;
      irq_flag   <= flag_sel ? full_c : empty_c;
    end
  end

endmodule

// File: rtl/txq_send_ctrl.sv
module txq_send_ctrl #(
  parameter int unsigned DEPTH = txq_pkg::TXQ_DEPTH,
  parameter int unsigned WIDTH = txq_pkg::TXQ_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mreset,
  input  logic             clear_cmd,
  input  logic             auto_mode,
  input  logic             flag_sel,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             load_end,
  input  logic             start_cmd,
  output logic             word_valid,
  output logic [WIDTH-1:0] word_data,
  input  logic             word_ready,
  input  logic             word_done,
  output logic             ser_flush,
  output logic             empty_flag,
  output logic             half_flag,
  output logic             full_flag,
  output logic             irq_flag
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  // named internal events, observed by the bound checker
  logic             flush;
  logic             push_ok;
  logic             take;
  logic             armed_q;
  logic             infl_q;
  logic             infl_nxt;
  logic [CNT_W-1:0] level_q;
  logic [CNT_W-1:0] level_nxt;

  assign flush     = clear_cmd || mreset;
  assign ser_flush = mreset;

  txq_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) level_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .wr_req   (wr_en),
    .pop      (take),
    .push_ok  (push_ok),
    .level_q  (level_q),
    .level_nxt(level_nxt)
  );

  txq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) store_i (
    .clk  (clk),
    .rst_n(rst_n),
    .flush(flush),
    .push (push_ok),
    .pop  (take),
    .wdata(wr_data),
    .rdata(word_data)
  );

  txq_release #(.CNT_W(CNT_W)) release_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mreset    (mreset),
    .clear_cmd (clear_cmd),
    .auto_mode (auto_mode),
    .load_end  (load_end),
    .start_cmd (start_cmd),
    .level_q   (level_q),
    .level_nxt (level_nxt),
    .word_ready(word_ready),
    .word_done (word_done),
    .word_valid(word_valid),
    .take      (take),
    .armed_q   (armed_q),
    .infl_q    (infl_q),
    .infl_nxt  (infl_nxt)
  );

  txq_flags #(.DEPTH(DEPTH), .CNT_W(CNT_W)) flags_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mreset    (mreset),
    .flag_sel  (flag_sel),
    .level_nxt (level_nxt),
    .infl_nxt  (infl_nxt),
    .empty_flag(empty_flag),
    .half_flag (half_flag),
    .full_flag (full_flag),
    .irq_flag  (irq_flag)
  );

endmodule

// File: rtl/txq_send_ctrl_chk.sv
module txq_send_ctrl_chk #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mreset,
  input logic             clear_cmd,
  input logic             wr_en,
  input logic             take,
  input logic             armed_q,
  input logic             infl_q,
  input logic [CNT_W-1:0] level_q,
  input logic             empty_flag,
  input logic             half_flag,
  input logic             full_flag,
  input logic             irq_flag,
  input logic             ser_flush
);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_LVL = CNT_W'(DEPTH / 2);

  always_comb begin
    if (rst_n) assert_no_overflow_R1: assert (level_q <= FULL_LVL);
  end

  assert_full_matches_R1: assert property (@(posedge clk) disable iff (!rst_n)
    full_flag |-> level_q == FULL_LVL);

  assert_half_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    half_flag |-> level_q >= HALF_LVL);

  assert_take_needs_trigger_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> armed_q && level_q != '0);

  assert_single_outstanding_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !infl_q);

  assert_empty_means_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    empty_flag |-> level_q == '0 && !infl_q);

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_cmd && !mreset) |=> level_q == '0);

  assert_mreset_zeroes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mreset |=> !empty_flag && !half_flag && !full_flag && !irq_flag && !infl_q && level_q == '0);

  assert_flush_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ser_flush |-> mreset);

  assert_balanced_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && take && level_q != FULL_LVL && !clear_cmd && !mreset) |=> level_q == $past(level_q));

endmodule

bind txq_send_ctrl txq_send_ctrl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .mreset    (mreset),
  .clear_cmd (clear_cmd),
  .wr_en     (wr_en),
  .take      (take),
  .armed_q   (armed_q),
  .infl_q    (infl_q),
  .level_q   (level_q),
  .empty_flag(empty_flag),
  .half_flag (half_flag),
  .full_flag (full_flag),
  .irq_flag  (irq_flag),
  .ser_flush (ser_flush)
);

// File: tb/txq_send_ctrl_tb.sv
`timescale 1ns/1ps
module txq_send_ctrl_tb_top;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mreset = 0, clear_cmd = 0, auto_mode = 0, flag_sel = 0;
  logic        wr_en = 0, load_end = 0, start_cmd = 0, word_ready = 0, word_done = 0;
  logic [31:0] wr_data = '0;
  logic        word_valid, ser_flush, empty_flag, half_flag, full_flag, irq_flag;
  logic [31:0] word_data;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  txq_send_ctrl #(.DEPTH(DEPTH), .WIDTH(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .mreset(mreset), .clear_cmd(clear_cmd),
    .auto_mode(auto_mode), .flag_sel(flag_sel), .wr_en(wr_en), .wr_data(wr_data),
    .load_end(load_end), .start_cmd(start_cmd), .word_valid(word_valid),
    .word_data(word_data), .word_ready(word_ready), .word_done(word_done),
    .ser_flush(ser_flush), .empty_flag(empty_flag), .half_flag(half_flag),
    .full_flag(full_flag), .irq_flag(irq_flag)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic push(input logic [31:0] d);
    wr_en = 1; wr_data = d; step(); wr_en = 0;
  endtask

  task automatic pulse_load_end();  load_end = 1;  step(); load_end = 0;  endtask
  task automatic pulse_start();     start_cmd = 1; step(); start_cmd = 0; endtask
  task automatic finish_word();     word_done = 1; step(); word_done = 0; endtask

  task automatic take_word(input string req, input logic [31:0] exp);
    eq({req, " valid"}, {31'd0, word_valid}, 32'd1);
    eq({req, " data"}, word_data, exp);
    word_ready = 1; step(); word_ready = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; step(); step();
    eq("reset empty held low", {31'd0, empty_flag}, 32'd0);
    rst_n = 1; step();
    eq("reset empty", {31'd0, empty_flag}, 32'd1);
    eq("reset full", {31'd0, full_flag}, 32'd0);
    eq("reset half", {31'd0, half_flag}, 32'd0);
    eq("reset valid", {31'd0, word_valid}, 32'd0);
    eq("R7 irq shows empty", {31'd0, irq_flag}, 32'd1);
  endtask

  task automatic t_auto_release();
    auto_mode = 1; flag_sel = 0;
    push(32'h0000_00A1); push(32'h0000_00B2); step();
    eq("R3 held before load_end", {31'd0, word_valid}, 32'd0);
    eq("R3 empty low with data", {31'd0, empty_flag}, 32'd0);
    pulse_start();
    eq("R4 start ignored in auto", {31'd0, word_valid}, 32'd0);
    pulse_load_end();
    take_word("R3 first word", 32'h0000_00A1);
    eq("R3 one outstanding", {31'd0, word_valid}, 32'd0);
    finish_word();
    take_word("R3 second word", 32'h0000_00B2);
    eq("R6 empty low while last in flight", {31'd0, empty_flag}, 32'd0);
    step();
    eq("R6 empty still low", {31'd0, empty_flag}, 32'd0);
    finish_word();
    eq("R6 empty after done", {31'd0, empty_flag}, 32'd1);
    eq("R7 irq follows empty", {31'd0, irq_flag}, 32'd1);
  endtask

  task automatic t_sw_release();
    auto_mode = 0;
    push(32'h5000_0000); push(32'h5000_0001); push(32'h5000_0002);
    pulse_load_end(); step();
    eq("R4 load_end ignored in sw", {31'd0, word_valid}, 32'd0);
    pulse_start();
    take_word("R4 w0", 32'h5000_0000);
    push(32'h5000_0003);
    finish_word();
    for (int i = 1; i < 4; i++) begin
      take_word("R4 drains incl mid-burst", 32'h5000_0000 + 32'(i));
      finish_word();
    end
    eq("R4 empty at burst end", {31'd0, empty_flag}, 32'd1);
    push(32'h5000_0004); step(); step();
    eq("R5 new word held", {31'd0, word_valid}, 32'd0);
    pulse_start();
    take_word("R5 sent on next start", 32'h5000_0004);
    finish_word();
  endtask

  task automatic t_fill();
    auto_mode = 0; flag_sel = 1;
    for (int i = 0; i < 15; i++) push(32'hA500_0000 + 32'(i));
    eq("R2 half at 15", {31'd0, half_flag}, 32'd0);
    push(32'hA500_000F);
    eq("R2 half at 16", {31'd0, half_flag}, 32'd1);
    for (int i = 16; i < 31; i++) push(32'hA500_0000 + 32'(i));
    eq("R1 not full at 31", {31'd0, full_flag}, 32'd0);
    push(32'hA500_001F);
    eq("R1 full at 32", {31'd0, full_flag}, 32'd1);
    eq("R7 irq shows full", {31'd0, irq_flag}, 32'd1);
    flag_sel = 0; step();
    eq("R7 irq shows empty", {31'd0, irq_flag}, 32'd0);
    push(32'hDEAD_BEEF);
    pulse_start();
    for (int i = 0; i < DEPTH; i++) begin
      take_word("R1 order", 32'hA500_0000 + 32'(i));
      if (i == 0) eq("R1 full drops after take", {31'd0, full_flag}, 32'd0);
      finish_word();
    end
    eq("R1 dropped word not offered", {31'd0, word_valid}, 32'd0);
    eq("R1 empty after drain", {31'd0, empty_flag}, 32'd1);
  endtask

  task automatic t_same_cycle_and_clear();
    auto_mode = 0; flag_sel = 0;
    for (int i = 0; i < 16; i++) push(32'hC000_0000 + 32'(i));
    pulse_start();
    eq("R10 valid before", {31'd0, word_valid}, 32'd1);
    wr_en = 1; wr_data = 32'hC000_0010; word_ready = 1; step();
    wr_en = 0; word_ready = 0;
    eq("R10 half kept with write+take", {31'd0, half_flag}, 32'd1);
    finish_word();
    take_word("R10 next word", 32'hC000_0001);
    eq("R10 half drops on take alone", {31'd0, half_flag}, 32'd0);
    clear_cmd = 1; wr_en = 1; wr_data = 32'hEEEE_0000; step();
    clear_cmd = 0; wr_en = 0;
    eq("R8 empty low while outstanding", {31'd0, empty_flag}, 32'd0);
    eq("R8 no fetch after clear", {31'd0, word_valid}, 32'd0);
    eq("R8 half cleared", {31'd0, half_flag}, 32'd0);
    finish_word();
    eq("R8 empty after done", {31'd0, empty_flag}, 32'd1);
    eq("R8 write with clear dropped", {31'd0, word_valid}, 32'd0);
  endtask

  task automatic t_mreset();
    auto_mode = 1; flag_sel = 0;
    push(32'h7700_0001); push(32'h7700_0002);
    pulse_load_end();
    take_word("R9 pre word", 32'h7700_0001);
    mreset = 1; #1;
    eq("R9 flush request", {31'd0, ser_flush}, 32'd1);
    step(); mreset = 0;
    eq("R9 empty zeroed", {31'd0, empty_flag}, 32'd0);
    eq("R9 irq zeroed", {31'd0, irq_flag}, 32'd0);
    eq("R9 valid low", {31'd0, word_valid}, 32'd0);
    step();
    eq("R9 empty after", {31'd0, empty_flag}, 32'd1);
    eq("R9 irq after", {31'd0, irq_flag}, 32'd1);
    push(32'h7700_0003);
    pulse_load_end();
    take_word("R9 outstanding forgotten", 32'h7700_0003);
    finish_word();
    eq("R9 empty at end", {31'd0, empty_flag}, 32'd1);
  endtask

  initial begin
    step();
    t_reset();
    t_auto_release();
    t_sw_release();
    t_fill();
    t_same_cycle_and_clear();
    t_mreset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule